// File: doc/BRIEF.md
# Command and Receive FIFO Pair with Interrupt Gathering

This block sits between a host register port and a serial-bus transfer sequencer. The host queues 11-bit command words for the sequencer and collects the 8-bit bytes the sequencer receives. Each direction has a 64-entry FIFO with its own clear control, a programmable level threshold and two sticky error flags: one for a push that was dropped, one for a pop that found nothing. Five interrupt sources are latched into a raw status vector. Two are single-cycle completion and fault pulses from the sequencer. One is the OR of the FIFO error flags. The other two are the receive almost-full and transmit almost-empty level conditions. A mask selects which sources reach the single interrupt line.

On the sequencer side, commands leave on a valid/pop stream. `tx_valid` is high whenever the transmit FIFO holds a word, and `tx_data` shows the oldest word. A cycle with `tx_pop` high removes that word. A `tx_pop` while `tx_valid` is low is an underflow. Received bytes arrive on a valid/ready stream. `rx_ready` is high while the receive FIFO has space, and a byte is taken in every cycle that `rx_valid` is high while `rx_ready` is high. Back-pressure is advisory: the sequencer must hold bytes while `rx_ready` is low. A byte offered anyway is dropped, and the drop is flagged.

Host accesses take one cycle. A write takes effect at the clock edge. Read data is valid combinationally in the same cycle as `reg_rd`. Word addresses: 0 FIFO control, 1 FIFO state, 2 command push, 3 receive pop, 4 interrupt mask, 5 masked status, 6 interrupt clear, 7 almost-empty clear.

Top module: `fifo_pair_irq`

## Requirements
- R1: After reset, both FIFOs are empty, so the FIFO state word reads 0x008. The control word, interrupt mask and masked status read 0, and `irq` is low.
- R2: Words written to address 2 (bits 10:0) appear on `tx_data` in write order. `tx_valid` is high while at least one word is held. A cycle with `tx_pop` and `tx_valid` high advances to the next word.
- R3: Bytes accepted from the receive stream are returned in arrival order by reads of address 3 (bits 7:0). Each such read removes one byte.
- R4: Each FIFO holds 64 entries. A full transmit FIFO sets state bit 11. A write to it is dropped and sets the transmit write-error flag (state bit 7). A full receive FIFO drops `rx_ready`, and a byte offered then is dropped and sets the receive write-error flag (state bit 1).
- R5: A `tx_pop` on an empty transmit FIFO sets state bit 6. A read of address 3 on an empty receive FIFO returns 0 and sets state bit 0. State bit 3 shows the receive FIFO is empty.
- R6: A control write with bit 0 set empties the receive FIFO and clears its error flags. Bit 1 does the same for the transmit FIFO. Both bits read back 0. Bits 7:2 store the receive threshold and bits 13:8 store the transmit threshold, and both read back.
- R7: Interrupt source 3 (receive almost-full) is set while the receive level is at or above the receive threshold.
- R8: Interrupt source 4 (transmit almost-empty) is set while the transmit level is at or below the transmit threshold. It is cleared only by writing 1 to bit 0 of address 7. Writing bit 4 at address 6 has no effect on it.
- R9: A `xfer_done` pulse latches source 0, and a `xfer_fault` pulse latches source 1, from the next cycle on.
- R10: Source 2 (FIFO error) is set while any of the four sticky FIFO error flags is set.
- R11: The mask at address 4 enables a source with a 1. Address 5 reads raw status AND mask, and `irq` is the OR of those bits. Writing 1 to a bit 0 to 3 at address 6 clears that source, unless its condition still holds in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 3 | Host word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, same cycle |
| tx_valid | output | 1 | Transmit FIFO holds a command word |
| tx_pop | input | 1 | Sequencer takes the head command word |
| tx_data | output | 11 | Head command word |
| rx_valid | input | 1 | Sequencer offers a received byte |
| rx_ready | output | 1 | Receive FIFO has space |
| rx_data | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse |
| xfer_fault | input | 1 | Transfer-error pulse |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong pointer or level count shows up at the ports within one transfer. It appears as an out-of-order or repeated word on `tx_data` or on a receive read, or as a full or empty state bit at the wrong entry count. Checking all 64 entries catches a wrap fault on the first lap. A raw interrupt bit that latches or clears at the wrong time is visible in the masked status one cycle after the triggering edge. The bench therefore reads the masked status around each threshold crossing, each clear write and each pulse.

// File: rtl/fifo_pair_irq_pkg.sv
package fifo_pair_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_FCTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_FSTATE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD    = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXD    = 3'd3;
  localparam logic [ADDR_W-1:0] A_IMASK  = 3'd4;
  localparam logic [ADDR_W-1:0] A_ISTAT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ICLR   = 3'd6;
  localparam logic [ADDR_W-1:0] A_AECLR  = 3'd7;

  localparam int unsigned N_IRQ    = 5;
  localparam int unsigned IRQ_DONE = 0;
  localparam int unsigned IRQ_FLT  = 1;
  localparam int unsigned IRQ_FIFO = 2;
  localparam int unsigned IRQ_RXAF = 3;
  localparam int unsigned IRQ_TXAE = 4;

  localparam int unsigned ST_RX_RERR  = 0;
  localparam int unsigned ST_RX_WERR  = 1;
  localparam int unsigned ST_RX_EMPTY = 3;
  localparam int unsigned ST_TX_RERR  = 6;
  localparam int unsigned ST_TX_WERR  = 7;
  localparam int unsigned ST_TX_FULL  = 11;
endpackage

// File: rtl/lvl_fifo.sv
module lvl_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           push,
  input  logic [WIDTH-1:0]               wdata,
  input  logic                           pop,
  output logic [WIDTH-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           empty,
  output logic                           full,
  output logic                           werr,
  output logic                           rerr
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == FULL_LVL);
  assign level   = count;
  assign rdata   = mem[rd_ptr];
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      werr   <= 1'b0;
      rerr   <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) werr <= 1'b1;
      if (pop && empty) rerr <= 1'b1;
    end
  end

  // R4
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr) |=> (werr && full));

  // R5
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr) |=> rerr);

  // R6
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !werr && !rerr));
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] mask,
  output logic [N-1:0] masked,
  output logic         irq
);
  logic [N-1:0] raw;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '0;
    else if (mask_we) mask <= mask_wdata;
  end

  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) raw[g] <= 1'b0;
      else        raw[g] <= set_ev[g] | (raw[g] & ~clr_ev[g]);
    end

    // R9
    src_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[g] |=> raw[g]);

    // R11
    src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ev[g] && !set_ev[g]) |=> !raw[g]);
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
  import fifo_pair_irq_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 64,
  parameter int unsigned RX_DEPTH = 64,
  parameter int unsigned CMD_W    = 11,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned THR_W    = 6,
  parameter int unsigned REG_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              tx_valid,
  input  logic              tx_pop,
  output logic [CMD_W-1:0]  tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              xfer_done,
  input  logic              xfer_fault,
  output logic              irq
);
  localparam int unsigned RXT_LSB = 2;
  localparam int unsigned TXT_LSB = RXT_LSB + THR_W;
  localparam int unsigned TX_LW   = $clog2(TX_DEPTH+1);
  localparam int unsigned RX_LW   = $clog2(RX_DEPTH+1);

  logic [THR_W-1:0]  rx_thr, tx_thr;
  logic              wr_ctrl, rx_clr, tx_clr;
  logic              tx_push, rx_pop;
  logic [TX_LW-1:0]  tx_level;
  logic [RX_LW-1:0]  rx_level;
  logic              tx_empty, tx_full, tx_werr, tx_rerr;
  logic              rx_empty, rx_full, rx_werr, rx_rerr;
  logic [BYTE_W-1:0] rx_head;
  logic [N_IRQ-1:0]  set_ev, clr_ev, mask, masked;
  logic              rx_af, tx_ae;
  logic              unused_wdata;

  assign wr_ctrl = reg_wr && (reg_addr == A_FCTRL);
  assign rx_clr  = wr_ctrl && reg_wdata[0];
  assign tx_clr  = wr_ctrl && reg_wdata[1];
  assign tx_push = reg_wr && (reg_addr == A_CMD);
  assign rx_pop  = reg_rd && (reg_addr == A_RXD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_thr <= '0;
      tx_thr <= '0;
    end else if (wr_ctrl) begin
      rx_thr <= reg_wdata[RXT_LSB +: THR_W];
      tx_thr <= reg_wdata[TXT_LSB +: THR_W];
    end
  end

  lvl_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .wdata(reg_wdata[CMD_W-1:0]),
    .pop(tx_pop), .rdata(tx_data), .level(tx_level),
    .empty(tx_empty), .full(tx_full), .werr(tx_werr), .rerr(tx_rerr)
  );

  lvl_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_valid), .wdata(rx_data),
    .pop(rx_pop), .rdata(rx_head), .level(rx_level),
    .empty(rx_empty), .full(rx_full), .werr(rx_werr), .rerr(rx_rerr)
  );

  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  assign rx_af = (int'(rx_level) >= int'(rx_thr));
  assign tx_ae = (int'(tx_level) <= int'(tx_thr));

  always_comb begin
    set_ev           = '0;
    set_ev[IRQ_DONE] = xfer_done;
    set_ev[IRQ_FLT]  = xfer_fault;
    set_ev[IRQ_FIFO] = tx_werr | tx_rerr | rx_werr | rx_rerr;
    set_ev[IRQ_RXAF] = rx_af;
    set_ev[IRQ_TXAE] = tx_ae;
    clr_ev = '0;
    if (reg_wr && (reg_addr == A_ICLR))
      clr_ev[IRQ_RXAF:0] = reg_wdata[IRQ_RXAF:0];
    clr_ev[IRQ_TXAE] = reg_wr && (reg_addr == A_AECLR) && reg_wdata[0];
  end

  irq_gather #(.N(N_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev),
    .mask_we(reg_wr && (reg_addr == A_IMASK)),
    .mask_wdata(reg_wdata[N_IRQ-1:0]),
    .mask(mask), .masked(masked), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_FCTRL: begin
        reg_rdata[RXT_LSB +: THR_W] = rx_thr;
        reg_rdata[TXT_LSB +: THR_W] = tx_thr;
      end
      A_FSTATE: begin
        reg_rdata[ST_RX_RERR]  = rx_rerr;
        reg_rdata[ST_RX_WERR]  = rx_werr;
        reg_rdata[ST_RX_EMPTY] = rx_empty;
        reg_rdata[ST_TX_RERR]  = tx_rerr;
        reg_rdata[ST_TX_WERR]  = tx_werr;
        reg_rdata[ST_TX_FULL]  = tx_full;
      end
      A_RXD:   if (!rx_empty) reg_rdata[BYTE_W-1:0] = rx_head;
      A_IMASK: reg_rdata[N_IRQ-1:0] = mask;
      A_ISTAT: reg_rdata[N_IRQ-1:0] = masked;
      default: reg_rdata = '0;
    endcase
  end

  assign unused_wdata = ^reg_wdata[REG_W-1:TXT_LSB+THR_W];
endmodule

// File: tb/fifo_pair_irq_tb.sv
`timescale 1ns/1ps
module fifo_pair_irq_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_pop = 0;
  logic [10:0] tx_data;
  logic        rx_valid = 0, rx_ready;
  logic [7:0]  rx_data = 0;
  logic        xfer_done = 0, xfer_fault = 0, irq;

  int n_chk = 0, n_fail = 0;
  logic [10:0] exp_q[$];
  logic [7:0]  rx_q[$];
  bit mon_en = 0, force_pop = 0;

  always #2 clk = ~clk;

  fifo_pair_irq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_valid(tx_valid), .tx_pop(tx_pop), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .xfer_done(xfer_done), .xfer_fault(xfer_fault), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic push_cmd(input logic [10:0] c, input bit expect_kept);
    if (expect_kept) exp_q.push_back(c);
    wr(3'd2, {21'd0, c});
  endtask

  task automatic send_byte(input logic [7:0] b, input bit expect_kept);
    if (expect_kept) rx_q.push_back(b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic pulse(input bit flt);
    @(negedge clk); if (flt) xfer_fault = 1; else xfer_done = 1;
    @(negedge clk); xfer_fault = 0; xfer_done = 0;
  endtask

  // scoreboard monitor on the command stream (R2)
  initial forever begin
    @(negedge clk);
    if (mon_en && tx_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected word", {21'd0, tx_data}, 32'hFFFF_FFFF);
      else chk("R2 order", {21'd0, tx_data}, {21'd0, exp_q.pop_front()});
      tx_pop = 1;
    end else tx_pop = force_pop;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    // R1 reset state
    rd(3'd1, d); chk("R1 state", d, 32'h008);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd4, d); chk("R1 mask", d, 0);
    rd(3'd5, d); chk("R1 masked", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R6 thresholds: rx 4, tx 2
    wr(3'd0, 32'h210);
    rd(3'd0, d); chk("R6 threshold readback", d, 32'h210);
    // R8 almost-empty set at level 0 <= 2; addr6 bit4 ignored
    wr(3'd4, 32'h10);
    rd(3'd5, d); chk("R8 txae set", d, 32'h10);
    wr(3'd6, 32'h10);
    rd(3'd5, d); chk("R8 addr6 no effect", d, 32'h10);
    push_cmd(11'h5A5, 1); push_cmd(11'h100, 1); push_cmd(11'h2FF, 1);
    wr(3'd7, 32'h1);
    rd(3'd5, d); chk("R8 own clear", d, 0);
    chk("R11 irq low", {31'd0, irq}, 0);
    // R2 drain
    mon_en = 1; wait (exp_q.size() == 0); repeat (3) @(posedge clk); mon_en = 0;
    chk("R2 tx_valid after drain", {31'd0, tx_valid}, 0);
    rd(3'd5, d); chk("R8 txae after drain", d, 32'h10);
    chk("R11 irq high", {31'd0, irq}, 1);
    // R5 tx underflow, R10 fifo error
    @(posedge clk); #1 force_pop = 1; @(posedge clk); #1 force_pop = 0;
    rd(3'd1, d); chk("R5 tx read error", d, 32'h048);
    wr(3'd4, 32'h04);
    rd(3'd5, d); chk("R10 fifo error source", d, 32'h04);
    wr(3'd0, 32'h212);
    rd(3'd1, d); chk("R6 tx clear flags", d, 32'h008);
    rd(3'd0, d); chk("R6 self-clear", d, 32'h210);
    rd(3'd5, d); chk("R11 latched until clear", d, 32'h04);
    wr(3'd6, 32'h04);
    rd(3'd5, d); chk("R11 w1c", d, 0);
    // R7 rx threshold
    wr(3'd4, 32'h08); wr(3'd6, 32'h08);
    rd(3'd5, d); chk("R11 rxaf cleared when below", d, 0);
    send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
    rd(3'd5, d); chk("R7 below threshold", d, 0);
    send_byte(8'h44, 1);
    rd(3'd5, d); chk("R7 at threshold", d, 32'h08);
    send_byte(8'h55, 1);
    wr(3'd6, 32'h08);
    rd(3'd5, d); chk("R11 set wins over clear", d, 32'h08);
    for (int i = 0; i < 5; i++) begin
      logic [7:0] e;
      e = rx_q.pop_front();
      rd(3'd3, d); chk("R3 rx order", d, {24'd0, e});
    end
    wr(3'd6, 32'h08);
    rd(3'd5, d); chk("R7 clears below threshold", d, 0);
    // R5 rx empty read
    rd(3'd3, d); chk("R5 empty read data", d, 0);
    rd(3'd1, d); chk("R5 rx read error", d, 32'h009);
    // R4 rx overflow
    for (int i = 0; i < 64; i++) send_byte(8'(i), 1);
    chk("R4 rx_ready low when full", {31'd0, rx_ready}, 0);
    send_byte(8'hEE, 0);
    rd(3'd1, d); chk("R4 rx write error", d, 32'h003);
    rd(3'd3, d); chk("R4 rx head kept", d, 32'h0);
    wr(3'd0, 32'h211); rx_q.delete();
    rd(3'd1, d); chk("R6 rx clear", d, 32'h008);
    chk("R6 rx_ready after clear", {31'd0, rx_ready}, 1);
    // R4 tx overflow
    for (int i = 0; i < 64; i++) push_cmd(11'((i * 37 + 5) & 11'h7FF), 1);
    rd(3'd1, d); chk("R4 tx full", d, 32'h808);
    push_cmd(11'h7FF, 0);
    rd(3'd1, d); chk("R4 tx write error", d, 32'h888);
    mon_en = 1; wait (exp_q.size() == 0); repeat (3) @(posedge clk); mon_en = 0;
    chk("R4 dropped word absent", {31'd0, tx_valid}, 0);
    rd(3'd1, d); chk("R4 tx state after drain", d, 32'h088);
    // R9 pulses
    wr(3'd4, 32'h03); wr(3'd6, 32'h1F);
    rd(3'd5, d); chk("R9 idle", d, 0);
    pulse(0);
    rd(3'd5, d); chk("R9 done latched", d, 32'h01);
    chk("R11 irq from done", {31'd0, irq}, 1);
    pulse(1);
    rd(3'd5, d); chk("R9 fault latched", d, 32'h03);
    wr(3'd6, 32'h01);
    rd(3'd5, d); chk("R11 w1c single bit", d, 32'h02);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule